// File: doc/BRIEF.md
# SPI Flash Boot-Stream Responder

This block is the device-side front end that lets a host fetch boot code from a serial flash without issuing any read instruction. After any reset the responder is armed. On the first chip-select assertion it lets a programmed number of SCK cycles pass with SO undriven. It then streams bytes from the array, most significant bit first, starting at a 512-byte-aligned base address and advancing one byte at a time until chip select is released.

When chip select is released after at least one full byte has been shifted out, the responder permanently hands the serial bus to the normal command decoder. From then on every chip-select cycle is a command transaction, until a power-up reset, a hardware reset or a command reset re-arms the boot stream. SCK, CS# and SO are treated as signals synchronous to the fabric clock `clk_i`, which runs at least 8 times faster than SCK. Array reads go through a one-cycle-latency byte port.

Top module: `boot_stream_resp`

## Requirements
- R1: After `rst_ni` is released, `so_oe_o`, `cmd_en_o` and `mem_req_o` are low and the responder is armed for a boot stream.
- R2: Data is presented MSB first. A new bit appears on `so_o` after each SCK falling edge, so the host samples each bit on the following SCK rising edge.
- R3: The first streamed byte is the array byte at address `start_blk_i` shifted left by 9 bits (the `start_blk_i` value 0 selects address 0).
- R4: After chip select falls, `delay_cyc_i` = D SCK rising edges pass with `so_oe_o` low. The first data bit is driven after the falling edge that follows the D-th rise. With D = 0 it is already valid before the first rise.
- R5: Each further byte comes from the next higher address for as long as chip select stays low.
- R6: A chip-select rise after at least 8 data bits sets `cmd_en_o` high.
- R7: While `cmd_en_o` is high, later chip-select cycles leave `so_oe_o` low and `cmd_en_o` high; no boot stream starts again.
- R8: A one-cycle pulse on `cmd_reset_i` clears `cmd_en_o` and re-arms the boot stream, as `rst_ni` does.
- R9: A chip-select rise before the first byte completes leaves the responder armed, and the next chip-select assertion restarts at the start address with the full delay.
- R10: The byte address wraps from the top of the `AW`-bit space to 0.
- R11: `so_oe_o` is low whenever `cs_ni` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock, at least 8x SCK |
| rst_ni | input | 1 | Active-low asynchronous reset (power-up and hardware) |
| cmd_reset_i | input | 1 | Command reset pulse from the command decoder |
| sck_i | input | 1 | Serial clock, synchronous to clk_i |
| cs_ni | input | 1 | Chip select, active low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for SO; low means SO is tri-stated |
| cmd_en_o | output | 1 | High once the bus belongs to the normal command decoder |
| mem_req_o | output | 1 | Array read strobe |
| mem_addr_o | output | AW | Array byte address |
| mem_data_i | input | 8 | Array data, valid the cycle after mem_req_o |
| start_blk_i | input | AW-9 | Start location in 512-byte units |
| delay_cyc_i | input | DW | Number of SCK delay cycles before data |

## Verification
The hardest state to reach is the address wrap at the top of the array. It only appears after more than a full 512-byte block has streamed without a break. The bench gets there by setting the start field to its largest value and holding chip select low for 514 bytes, comparing every bit against its image function. The early-abort path needs a release in the middle of the first byte, followed by a second session that must restart at the base address with the full delay. The bench drives exactly that sequence after a hardware reset.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam int BLK_SHIFT = 9;

  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,
    ST_DELAY  = 2'd1,
    ST_STREAM = 2'd2,
    ST_CMD    = 2'd3
  } boot_state_e;
endpackage

// File: rtl/boot_edges.sv
module boot_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_fall_o,
  output logic cs_rise_o
);
  logic sck_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
    end
  end

  assign sck_rise_o = sck_i & ~sck_q;
  assign sck_fall_o = ~sck_i & sck_q;
  assign cs_fall_o  = ~cs_ni & cs_q;
  assign cs_rise_o  = cs_ni & ~cs_q;
endmodule

// File: rtl/boot_fetch.sv
module boot_fetch #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          next_i,
  input  logic [AW-1:0] base_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_data_i,
  output logic [7:0]    buf_o,
  output logic          buf_vld_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_req_o  <= 1'b0;
      mem_addr_o <= '0;
      pend_q     <= 1'b0;
      buf_o      <= '0;
      buf_vld_o  <= 1'b0;
    end else begin
      mem_req_o <= start_i | next_i;
      pend_q    <= mem_req_o;
      if (start_i) begin
        mem_addr_o <= base_i;
        buf_vld_o  <= 1'b0;
      end else if (next_i) begin
        mem_addr_o <= mem_addr_o + 1'b1;  // wraps at top of space
        buf_vld_o  <= 1'b0;
      end else if (pend_q) begin
        buf_o     <= mem_data_i;
        buf_vld_o <= 1'b1;
      end
    end
  end

  p_start_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (mem_req_o && mem_addr_o == $past(base_i)));

  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (next_i && !start_i) |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + 1'b1));
endmodule

// File: rtl/boot_shifter.sv
module boot_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       shift_i,
  input  logic [7:0] din_i,
  output logic       msb_o,
  output logic       bit_last_o
);
  logic [7:0] sh_q;
  logic [2:0] bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bcnt_q <= '0;
    end else if (load_i) begin
      sh_q   <= din_i;
      bcnt_q <= '0;
    end else if (shift_i) begin
      sh_q   <= {sh_q[6:0], 1'b0};
      bcnt_q <= bcnt_q + 1'b1;
    end
  end

  assign msb_o      = sh_q[7];
  assign bit_last_o = (bcnt_q == 3'd7);

  p_msb_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> (msb_o == $past(sh_q[6]) && bcnt_q == $past(bcnt_q) + 1'b1));
endmodule

// File: rtl/boot_stream_resp.sv
module boot_stream_resp
  import boot_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_reset_i,
  input  logic                  sck_i,
  input  logic                  cs_ni,
  output logic                  so_o,
  output logic                  so_oe_o,
  output logic                  cmd_en_o,
  output logic                  mem_req_o,
  output logic [AW-1:0]         mem_addr_o,
  input  logic [7:0]            mem_data_i,
  input  logic [AW-BLK_SHIFT-1:0] start_blk_i,
  input  logic [DW-1:0]         delay_cyc_i
);
  boot_state_e state_q, state_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic          done_q, done_d;
  logic          sck_rise, sck_fall, cs_fall, cs_rise;
  logic          f_start, f_next, s_load, s_shift;
  logic [7:0]    buf_data;
  logic          buf_vld, bit_last, msb;
  logic [AW-1:0] base;

  assign base = {start_blk_i, {BLK_SHIFT{1'b0}}};

  boot_edges i_edges (
    .clk_i, .rst_ni, .sck_i, .cs_ni,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
    .cs_fall_o(cs_fall), .cs_rise_o(cs_rise)
  );

  boot_fetch #(.AW(AW)) i_fetch (
    .clk_i, .rst_ni,
    .start_i(f_start), .next_i(f_next), .base_i(base),
    .mem_req_o, .mem_addr_o, .mem_data_i,
    .buf_o(buf_data), .buf_vld_o(buf_vld)
  );

  boot_shifter i_shift (
    .clk_i, .rst_ni,
    .load_i(s_load), .shift_i(s_shift), .din_i(buf_data),
    .msb_o(msb), .bit_last_o(bit_last)
  );

  always_comb begin
    state_d = state_q;
    dcnt_d  = dcnt_q;
    done_d  = done_q;
    f_start = 1'b0;
    f_next  = 1'b0;
    s_load  = 1'b0;
    s_shift = 1'b0;
    if (cmd_reset_i) begin
      state_d = ST_ARMED;
      dcnt_d  = '0;
      done_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_ARMED: if (cs_fall) begin
          state_d = ST_DELAY;
          dcnt_d  = '0;
          done_d  = 1'b0;
          f_start = 1'b1;
        end
        ST_DELAY: begin
          if (cs_rise) state_d = ST_ARMED;
          else if (dcnt_q != delay_cyc_i) begin
            if (sck_rise) dcnt_d = dcnt_q + 1'b1;
          end else if (buf_vld && (delay_cyc_i == '0 || sck_fall)) begin
            // first bit goes out on the fall after the last delay rise
            state_d = ST_STREAM;
            s_load  = 1'b1;
            f_next  = 1'b1;
          end
        end
        ST_STREAM: begin
          if (cs_rise) state_d = done_q ? ST_CMD : ST_ARMED;
          else begin
            if (sck_rise && bit_last) done_d = 1'b1;
            if (sck_fall) begin
              if (bit_last) begin
                s_load = 1'b1;
                f_next = 1'b1;
              end else s_shift = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ARMED;
      dcnt_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dcnt_q  <= dcnt_d;
      done_q  <= done_d;
    end
  end

  assign so_oe_o  = (state_q == ST_STREAM) && !cs_ni;
  assign so_o     = so_oe_o & msb;
  assign cmd_en_o = (state_q == ST_CMD);

  p_cmd_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMD && !cmd_reset_i) |=> state_q == ST_CMD);

  p_rearm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_reset_i |=> (state_q == ST_ARMED && !cmd_en_o));

  p_early_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STREAM && !done_q && cs_rise && !cmd_reset_i) |=> state_q == ST_ARMED);

  p_delay_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DELAY && !cmd_reset_i && !cs_rise && sck_rise && dcnt_q != delay_cyc_i)
      |=> (dcnt_q == $past(dcnt_q) + 1'b1 && !so_oe_o));
endmodule

// File: tb/test_boot_stream_resp.sv
`timescale 1ns/1ps
module test_boot_stream_resp;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int SW = AW - 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_reset = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic so, so_oe, cmd_en, mem_req;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata = 8'h00;
  logic [SW-1:0] start_blk = '0;
  logic [DW-1:0] delay_cyc = '0;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  boot_stream_resp #(.AW(AW), .DW(DW)) i_boot_stream_resp (
    .clk_i(clk), .rst_ni(rst_n), .cmd_reset_i(cmd_reset),
    .sck_i(sck), .cs_ni(cs_n), .so_o(so), .so_oe_o(so_oe),
    .cmd_en_o(cmd_en), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_data_i(mem_rdata), .start_blk_i(start_blk), .delay_cyc_i(delay_cyc)
  );

  function automatic logic [7:0] img(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] + 8'h3C);
  endfunction

  // behavioural array: one-cycle read latency
  always @(posedge clk) if (mem_req) mem_rdata <= img(mem_addr);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // wait n clocks, optionally checking SO stays undriven on each
  task automatic idle(input int n, input bit quiet, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (quiet) chk(so_oe == 1'b0, tag, so_oe, 0);
    end
  endtask

  task automatic session(input int sblk, input int dly, input int nbits, input string tag);
    start_blk = sblk[SW-1:0];
    delay_cyc = dly[DW-1:0];
    @(negedge clk);
    cs_n = 1'b0;
    idle(8, dly > 0, {tag, " R4 oe before delay"});
    for (int d = 0; d < dly; d++) begin
      sck = 1'b1;
      idle(4, 1'b1, {tag, " R4 oe in delay"});
      sck = 1'b0;
      idle(4, d < dly - 1, {tag, " R4 oe in delay"});
    end
    for (int k = 0; k < nbits; k++) begin
      logic [15:0] ea;
      logic [7:0] eb;
      ea = 16'((sblk << 9) + k / 8);
      eb = img(ea);
      chk(so_oe == 1'b1, {tag, " R4 oe in data"}, so_oe, 1);
      chk(so == eb[7 - k % 8], {tag, " R2 R3 R5 R10 data bit"}, so, eb[7 - k % 8]);
      sck = 1'b1;
      idle(4, 1'b0, tag);
      sck = 1'b0;
      idle(4, 1'b0, tag);
    end
    idle(2, 1'b0, tag);
    cs_n = 1'b1;
    idle(4, 1'b1, {tag, " R11 oe with cs high"});
  endtask

  task automatic cmd_cycle(input string tag);
    @(negedge clk);
    cs_n = 1'b0;
    idle(6, 1'b1, {tag, " R7 oe in cmd mode"});
    for (int b = 0; b < 16; b++) begin
      sck = 1'b1;
      idle(4, 1'b1, {tag, " R7 oe in cmd mode"});
      sck = 1'b0;
      idle(4, 1'b1, {tag, " R7 oe in cmd mode"});
    end
    cs_n = 1'b1;
    idle(4, 1'b1, {tag, " R11 oe with cs high"});
    chk(cmd_en == 1'b1, {tag, " R7 cmd_en kept"}, cmd_en, 1);
  endtask

  task automatic pulse_cmd_reset();
    @(negedge clk);
    cmd_reset = 1'b1;
    @(negedge clk);
    cmd_reset = 1'b0;
    idle(2, 1'b1, "R8 oe after cmd reset");
    chk(cmd_en == 1'b0, "R8 cmd_en cleared", cmd_en, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3, 1'b0, "reset");
    rst_n = 1'b1;
    idle(2, 1'b0, "reset");
    chk(so_oe == 1'b0, "R1 so_oe after reset", so_oe, 0);
    chk(cmd_en == 1'b0, "R1 cmd_en after reset", cmd_en, 0);
    chk(mem_req == 1'b0, "R1 mem_req after reset", mem_req, 0);

    // zero delay, base 0
    session(0, 0, 160, "S1");
    chk(cmd_en == 1'b1, "R6 cmd_en after boot", cmd_en, 1);
    cmd_cycle("S1b");
    cmd_cycle("S1c");

    // command reset, nonzero delay, nonzero start
    pulse_cmd_reset();
    session(5, 3, 80, "S2");
    chk(cmd_en == 1'b1, "R6 cmd_en after boot", cmd_en, 1);

    // hardware reset, abort inside first byte, then restart
    @(negedge clk);
    rst_n = 1'b0;
    idle(2, 1'b0, "reset");
    rst_n = 1'b1;
    idle(2, 1'b1, "R1 oe after second reset");
    chk(cmd_en == 1'b0, "R1 cmd_en after second reset", cmd_en, 0);
    session(9, 2, 5, "S3");
    chk(cmd_en == 1'b0, "R9 still armed after abort", cmd_en, 0);
    session(9, 2, 24, "S3r R9 restart");
    chk(cmd_en == 1'b1, "R6 cmd_en after boot", cmd_en, 1);

    // wrap across the top of the address space
    pulse_cmd_reset();
    session((1 << SW) - 1, 1, 514 * 8, "S4 R10");
    chk(cmd_en == 1'b1, "R6 cmd_en after boot", cmd_en, 1);
    cmd_cycle("S4b");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule